// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Receiver

This block is a slave-only receiver for a two-wire serial bus in the style of I2C or SMBus. It lets a host load a small bank of control registers in a clock-generator controller. Both bus lines pass through synchronizers and are sampled with the system clock, which must run at least eight times faster than the serial clock. The block detects START and STOP conditions and compares the first byte of each transaction with its own fixed 8-bit address. It acknowledges each byte after a matching address and keeps count of the bytes in the transaction.

A transaction has a fixed byte layout. The address byte comes first. The command byte, the count byte and three leading data bytes are then received, acknowledged and thrown away. Only the four data bytes that follow are stored, one in each control register. The full register bank is driven in parallel to the rest of the chip. The registers start at their default values when reset is released, so the chip can run without any bus traffic at all. The bus cannot read anything back.

Top module: `cfg_wr_rx`

## Requirements
- R1: While reset is held, and after it is released with no bus traffic, `cfg_word_o` equals the default value 32'h13EF4702.
- R2: Serial bits are taken most significant bit first and are sampled on each rising edge of SCL. Byte positions count from 0, which is the address byte. Bytes at positions 6, 7, 8 and 9 are stored in `cfg_word_o[7:0]`, `[15:8]`, `[23:16]` and `[31:24]` respectively.
- R3: Once the address byte equals 8'hD2, the block pulls SDA low (`sda_pull_o` = 1) through the ninth SCL clock of every byte in the transaction, the address byte included. After any other address it never pulls SDA.
- R4: If the address byte is not exactly 8'hD2, no register changes for the rest of that transaction. This holds even when the address differs only in its lowest bit.
- R5: The bytes at positions 1 through 5 are acknowledged but never change any register.
- R6: Every bit of a stored byte is kept exactly as it was sent, reserved positions included.
- R7: A STOP in the middle of a byte throws that byte away. Bytes that were completed before the STOP keep their effect.
- R8: A repeated START ends the current transaction and starts a new address phase at position 0.
- R9: Bytes beyond position 9 are acknowledged and change no register.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_pull_o | output | 1 | 1 = drive SDA low (acknowledge) |
| cfg_word_o | output | 32 | Control register bank, register k at bits [8k+7:8k] |

## Verification
The bench works on the byte count. A design that is off by one position would store the command or count byte, or would shift every register by one byte. Mismatched addresses are sent with the same data patterns as matched ones, and one of them differs from the real address only in its lowest bit, so a compare that masks that bit would overwrite the bank. A transaction is cut off by STOP in the middle of a byte, and another is restarted by a repeated START. Either one catches a design that commits partial bytes or fails to reset its position count. A trailing eleventh byte catches a counter that wraps around and writes the first register a second time.

// File: rtl/cfg_rx_pkg.sv
// Shared types for the two-wire configuration receiver.
package cfg_rx_pkg;

    // Sequencer phases of the frame engine
    typedef enum logic [2:0] {
        RX_IDLE,      // no transaction open
        RX_BITS,      // shifting in the 8 data bits of a byte
        RX_ACK_WAIT,  // 8th bit taken, waiting for SCL to fall
        RX_ACK_DRV,   // pulling SDA through the 9th clock
        RX_SKIP       // address mismatch, ignore until START/STOP
    } rx_state_e;

endpackage

// File: rtl/cfg_rx_sync.sv
// Two-flop synchronizer bank for asynchronous bus lines.
// Assumes: inputs idle high, so flops reset to 1 to avoid false edges.
module cfg_rx_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;

            // Shift the raw line through the metastability chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], async_i[g]};
            end

            assign sync_o[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/cfg_rx_frame.sv
// Frame engine: START/STOP detection, bit shifting, address compare,
// byte position counting and acknowledge timing.
// Assumes: synchronized SCL/SDA, each SCL phase lasts several clk cycles.
module cfg_rx_frame
    import cfg_rx_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR    = 8'hD2,
    parameter int         FRAME_BYTES = 10,
    localparam int        POS_W       = $clog2(FRAME_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    output logic [7:0]       byte_val,
    output logic             byte_stb,
    output logic [POS_W-1:0] byte_pos,
    output logic             addr_ok,
    output logic             sda_pull
);

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_BYTES);

    rx_state_e   state;
    logic        scl_d, sda_d;
    logic [2:0]  bit_cnt;
    logic        ack_rise_seen;
    logic        scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]  next_shift;

    // Bus event decode from current and previous synchronized levels
    always_comb begin
        scl_rise   = scl_s & ~scl_d;
        scl_fall   = ~scl_s & scl_d;
        start_det  = scl_s & scl_d & sda_d & ~sda_s;
        stop_det   = scl_s & scl_d & ~sda_d & sda_s;
        next_shift = {byte_val[6:0], sda_s};
    end

    // Sequencer, shift register and acknowledge driver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= RX_IDLE;
            scl_d         <= 1'b1;
            sda_d         <= 1'b1;
            bit_cnt       <= '0;
            byte_val      <= '0;
            byte_stb      <= 1'b0;
            byte_pos      <= '0;
            addr_ok       <= 1'b0;
            sda_pull      <= 1'b0;
            ack_rise_seen <= 1'b0;
        end else begin
            scl_d    <= scl_s;
            sda_d    <= sda_s;
            byte_stb <= 1'b0;
            if (start_det) begin
                state    <= RX_BITS;
                bit_cnt  <= '0;
                byte_pos <= '0;
                addr_ok  <= 1'b0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= RX_IDLE;
                addr_ok  <= 1'b0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    RX_BITS: begin
                        if (scl_rise) begin
                            byte_val <= next_shift;
                            if (bit_cnt == 3'd7) begin
                                bit_cnt  <= '0;
                                byte_stb <= 1'b1;
                                if (byte_pos == '0) begin
                                    if (next_shift == DEV_ADDR) begin
                                        addr_ok <= 1'b1;
                                        state   <= RX_ACK_WAIT;
                                    end else begin
                                        state   <= RX_SKIP;
                                    end
                                end else begin
                                    state <= RX_ACK_WAIT;
                                end
                            end else begin
                                bit_cnt <= bit_cnt + 3'd1;
                            end
                        end
                    end
                    RX_ACK_WAIT: begin
                        if (scl_fall) begin
                            sda_pull      <= 1'b1;
                            ack_rise_seen <= 1'b0;
                            state         <= RX_ACK_DRV;
                        end
                    end
                    RX_ACK_DRV: begin
                        if (scl_rise) ack_rise_seen <= 1'b1;
                        if (scl_fall && ack_rise_seen) begin
                            sda_pull <= 1'b0;
                            state    <= RX_BITS;
                            if (byte_pos != POS_LAST) byte_pos <= byte_pos + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cfg_rx_regs.sv
// Control register bank: stores the data bytes of the write window.
// Assumes: byte_stb is a one-cycle pulse aligned with byte_val/byte_pos.
module cfg_rx_regs #(
    parameter int                         NUM_REGS  = 4,
    parameter int                         REG_W     = 8,
    parameter int                         FIRST_POS = 6,
    parameter int                         POS_W     = 4,
    parameter logic [NUM_REGS*REG_W-1:0]  DEFAULTS  = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [REG_W-1:0]            byte_val,
    input  logic                        byte_stb,
    input  logic [POS_W-1:0]            byte_pos,
    input  logic                        addr_ok,
    output logic [NUM_REGS*REG_W-1:0]   cfg_word
);

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            localparam logic [POS_W-1:0] MY_POS = POS_W'(FIRST_POS + g);

            // Load this register when its byte position completes
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_word[g*REG_W +: REG_W] <= DEFAULTS[g*REG_W +: REG_W];
                else if (byte_stb && addr_ok && byte_pos == MY_POS)
                    cfg_word[g*REG_W +: REG_W] <= byte_val;
            end
        end
    endgenerate

endmodule

// File: rtl/cfg_wr_rx.sv
// Top: write-only two-wire configuration receiver.
// Assumes: clk at least 8x SCL; bus lines idle high; pin SDA is the
// wired-AND of the master and an open-drain driver controlled by sda_pull_o.
module cfg_wr_rx #(
    parameter logic [7:0]  DEV_ADDR    = 8'hD2,
    parameter int          NUM_REGS    = 4,
    parameter int          FIRST_POS   = 6,
    parameter logic [31:0] DEFAULTS    = 32'h13EF4702,
    localparam int         REG_W       = 8,
    localparam int         FRAME_BYTES = FIRST_POS + NUM_REGS,
    localparam int         POS_W       = $clog2(FRAME_BYTES + 1),
    localparam int         CFG_W       = NUM_REGS * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    output logic [CFG_W-1:0] cfg_word_o
);

    logic [1:0]       sync_q;
    logic             scl_s, sda_s;
    logic [7:0]       byte_val;
    logic             byte_stb;
    logic [POS_W-1:0] byte_pos;
    logic             addr_ok;

    cfg_rx_sync #(.LINES(2), .STAGES(2)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (sync_q)
    );

    assign scl_s = sync_q[1];
    assign sda_s = sync_q[0];

    cfg_rx_frame #(.DEV_ADDR(DEV_ADDR), .FRAME_BYTES(FRAME_BYTES)) frame_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .byte_val (byte_val),
        .byte_stb (byte_stb),
        .byte_pos (byte_pos),
        .addr_ok  (addr_ok),
        .sda_pull (sda_pull_o)
    );

    cfg_rx_regs #(
        .NUM_REGS  (NUM_REGS),
        .REG_W     (REG_W),
        .FIRST_POS (FIRST_POS),
        .POS_W     (POS_W),
        .DEFAULTS  (DEFAULTS[CFG_W-1:0])
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_val (byte_val),
        .byte_stb (byte_stb),
        .byte_pos (byte_pos),
        .addr_ok  (addr_ok),
        .cfg_word (cfg_word_o)
    );

endmodule

// File: rtl/cfg_wr_rx_chk.sv
// Property checker for cfg_wr_rx, attached by bind below.
module cfg_wr_rx_chk #(
    parameter int              CFG_W    = 32,
    parameter logic [CFG_W-1:0] DEFAULTS = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_pull,
    input logic             addr_ok,
    input logic             byte_stb,
    input logic [CFG_W-1:0] cfg_word
);

    // R1: reset loads the defaults
    p_reset_defaults_r1: assert property (@(posedge clk)
        !rst_n |=> cfg_word == DEFAULTS);

    // R3: acknowledge only inside a matched transaction
    p_ack_needs_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> addr_ok);

    // R3: acknowledge starts while SCL is low
    p_ack_in_low_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R4: without an address match the bank holds
    p_no_write_unmatched_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ok |=> $stable(cfg_word));

    // R7: registers change only on a completed byte
    p_write_on_byte_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |=> $stable(cfg_word));

endmodule

bind cfg_wr_rx cfg_wr_rx_chk #(.CFG_W(CFG_W), .DEFAULTS(DEFAULTS[CFG_W-1:0])) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_pull (sda_pull_o),
    .addr_ok  (addr_ok),
    .byte_stb (byte_stb),
    .cfg_word (cfg_word_o)
);

// File: tb/cfg_wr_rx_tb_top.sv
// Self-checking bench for cfg_wr_rx: vector table, then directed cases.
module cfg_wr_rx_tb_top;

    localparam int HALF = 10;   // SCL half period in clk cycles
    localparam logic [31:0] DEF = 32'h13EF4702;

    // Vector: {10 frame bytes, expected bank, expected ack count}
    localparam int NVEC = 4;
    localparam logic [115:0] VECS [NVEC] = '{
        {80'hD2_00_0A_11_22_33_A1_B2_C3_D4, 32'hD4C3B2A1, 4'd10},  // R2 R3 R6
        {80'hD0_00_0A_11_22_33_55_66_77_88, 32'hD4C3B2A1, 4'd0 },  // R3 R4
        {80'hD2_FF_FF_FF_FF_FF_00_80_01_5A, 32'h5A018000, 4'd10},  // R5
        {80'hD3_00_0A_00_00_00_99_99_99_99, 32'h5A018000, 4'd0 }   // R4 low bit
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_pull;
    logic [31:0] cfg_word;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic        ack_bit;
    int          acks;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    cfg_wr_rx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .cfg_word_o (cfg_word)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(HALF/2);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(HALF/2);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wait_clk(HALF/2);
        scl_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF/2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_clk(HALF/2);
        scl_m = 1'b1; wait_clk(HALF/2);
        ack = ~sda_line;
        wait_clk(HALF/2);
        scl_m = 1'b0; wait_clk(HALF/2);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(4);
        check("R1 default during reset", cfg_word, DEF);
        rst_n = 1'b1;
        wait_clk(20);
        check("R1 default after reset", cfg_word, DEF);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            acks = 0;
            bus_start();
            for (int i = 0; i < 10; i++) begin
                send_byte(VECS[v][115-8*i -: 8], ack_bit);
                if (ack_bit) acks++;
            end
            bus_stop();
            wait_clk(5);
            check($sformatf("R2/R4/R5/R6 vector %0d bank", v), cfg_word, VECS[v][35:4]);
            check($sformatf("R3 vector %0d ack count", v), 32'(acks), 32'(VECS[v][3:0]));
        end

        // R7: STOP in the middle of byte 7 keeps byte 6
        bus_start();
        send_byte(8'hD2, ack_bit); send_byte(8'h00, ack_bit); send_byte(8'h0A, ack_bit);
        send_byte(8'h00, ack_bit); send_byte(8'h00, ack_bit); send_byte(8'h00, ack_bit);
        send_byte(8'h77, ack_bit);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        wait_clk(5);
        check("R7 partial byte dropped", cfg_word, 32'h5A018077);

        // R5: frame ending after position 5 changes nothing
        bus_start();
        send_byte(8'hD2, ack_bit); send_byte(8'hAB, ack_bit); send_byte(8'hCD, ack_bit);
        send_byte(8'hEF, ack_bit); send_byte(8'h01, ack_bit); send_byte(8'h23, ack_bit);
        check("R5 header byte acknowledged", 32'(ack_bit), 32'd1);
        bus_stop();
        wait_clk(5);
        check("R5 header bytes ignored", cfg_word, 32'h5A018077);

        // R8: repeated START realigns positions; R6 all-ones stored
        bus_start();
        send_byte(8'hD2, ack_bit); send_byte(8'h00, ack_bit); send_byte(8'h0A, ack_bit);
        bus_start();
        send_byte(8'hD2, ack_bit); send_byte(8'h00, ack_bit); send_byte(8'h0A, ack_bit);
        send_byte(8'h00, ack_bit); send_byte(8'h00, ack_bit); send_byte(8'h00, ack_bit);
        send_byte(8'hFF, ack_bit); send_byte(8'h0F, ack_bit); send_byte(8'hF0, ack_bit);
        send_byte(8'h3C, ack_bit);
        bus_stop();
        wait_clk(5);
        check("R8/R6 repeated start realign", cfg_word, 32'h3CF00FFF);

        // R9: an eleventh byte is acknowledged and ignored
        bus_start();
        send_byte(8'hD2, ack_bit); send_byte(8'h00, ack_bit); send_byte(8'h0A, ack_bit);
        send_byte(8'h00, ack_bit); send_byte(8'h00, ack_bit); send_byte(8'h00, ack_bit);
        send_byte(8'h10, ack_bit); send_byte(8'h20, ack_bit); send_byte(8'h30, ack_bit);
        send_byte(8'h40, ack_bit);
        send_byte(8'hEE, ack_bit);
        check("R9 extra byte acknowledged", 32'(ack_bit), 32'd1);
        bus_stop();
        wait_clk(5);
        check("R9 extra byte ignored", cfg_word, 32'h40302010);

        // R1: reset mid-run restores defaults
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        check("R1 defaults after second reset", cfg_word, DEF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule